// File: doc/BRIEF.md
# Indexed interrupt mapper controller

This block collects a parameterised number of system interrupt lines and folds them onto a smaller set of host interrupt lines. A rising edge on a system line latches a sticky raw status bit. A per-source enable masks that bit. A byte per source, the channel map, picks the host line that the source drives. Each host line is then gated by its own host enable and by one global enable, and is registered before it leaves the block.

Software works on the block through a plain 32-bit register port with write enable, address and write data, and a read data bus that follows the address. Single bits can be changed by writing a bit index to a dedicated set or clear register, with no read-modify-write. Whole words of status and enable bits can be handled through bitmap registers. The channel map is byte-addressable state, packed four sources to a word.

Top module: `irq_mapper_ctrl`

## Requirements
- R1: After reset all raw status bits, source enables, host enables, channel map bytes and the global enable are zero, and every host output is low.
- R2: A rising edge on a system input sets its raw status bit. The bit stays set after the input falls until software clears it. An input held high does not set the bit again after a clear.
- R3: Writing a source index to offset 0x20 sets that raw status bit. Writing it to offset 0x24 clears it.
- R4: Writing a source index to offset 0x28 enables that source. Writing it to offset 0x2C disables it.
- R5: Writing a host number to offset 0x34 enables that host output. Writing it to offset 0x38 disables it.
- R6: Bit 0 of offset 0x10 is the global enable. It reads back there, and writing it leaves every host enable unchanged.
- R7: The channel map starts at offset 0x400, with byte k of word w (bits 8k+7:8k) holding the channel of source 4w+k. It reads back as written.
- R8: Word w at 0x200+4w reads raw status of sources 32w..32w+31 (bit b = source 32w+b), and a 1 written to it sets that bit. Word w at 0x280+4w reads raw AND enable, and a 1 written to it clears that raw bit.
- R9: Word w at 0x300+4w sets enables where a 1 is written, word w at 0x380+4w clears them, and both read the current enables.
- R10: Host output n goes high one clock after the edge on which global enable, host enable n and a pending enabled source mapped to channel n are all present.
- R11: A host output stays high while any of the enabled sources mapped to it is still pending.
- R12: Index writes whose value is at least the source or host count change nothing. A map byte that names a channel at or above the host count routes its source to no output.
- R13: When a set (input edge or software) and a clear hit the same raw bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_irq | input | N_SRC | System interrupt inputs, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 13 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| host_irq | output | N_HOST | Registered host interrupt outputs |

## Verification
The bench builds the block with 40 sources and 6 host lines rather than the defaults. Forty sources leave the second status and enable word only partly used, so index 40 is a real out-of-range value one past the last source, and sources on both sides of the word boundary share a host line. Six host lines leave map byte values 6 and 7 naming channels that do not exist, and host number 6 serves as an out-of-range index write.

// File: rtl/cimap_pkg.sv
package cimap_pkg;
   localparam int AW = 13;
   localparam int DW = 32;

   // single registers
   localparam logic [AW-1:0] OFS_GEN   = 13'h010;
   localparam logic [AW-1:0] OFS_SSET  = 13'h020;
   localparam logic [AW-1:0] OFS_SCLR  = 13'h024;
   localparam logic [AW-1:0] OFS_ESET  = 13'h028;
   localparam logic [AW-1:0] OFS_ECLR  = 13'h02C;
   localparam logic [AW-1:0] OFS_HSET  = 13'h034;
   localparam logic [AW-1:0] OFS_HCLR  = 13'h038;

   // bitmap regions, 128 bytes each
   localparam logic [AW-1:0] BASE_RAW  = 13'h200;
   localparam logic [AW-1:0] BASE_PEND = 13'h280;
   localparam logic [AW-1:0] BASE_ENS  = 13'h300;
   localparam logic [AW-1:0] BASE_ENC  = 13'h380;
   localparam logic [AW-1:0] BASE_MAP  = 13'h400;

   localparam int MAX_SRC  = 1024;
   localparam int MAX_HOST = 256;
endpackage

// File: rtl/cimap_busdec.sv
module cimap_busdec
   import cimap_pkg::*;
#(
   parameter int N_SRC     = 64,
   parameter int N_HOST    = 8,
   parameter int MAP_WORDS = (N_SRC + 3) / 4
) (
   input  logic                 bus_we,
   input  logic [AW-1:0]        bus_addr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [N_SRC-1:0]     sw_set,
   output logic [N_SRC-1:0]     sw_clr,
   output logic [N_SRC-1:0]     en_set,
   output logic [N_SRC-1:0]     en_clr,
   output logic [N_HOST-1:0]    hen_set,
   output logic [N_HOST-1:0]    hen_clr,
   output logic                 gen_we,
   output logic [MAP_WORDS-1:0] map_we
);
   // index registers match only exact in-range values
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam int W = i / 32;
      localparam int B = i % 32;
      localparam logic [AW-1:0] A_RAW  = BASE_RAW  + AW'(4 * W);
      localparam logic [AW-1:0] A_PEND = BASE_PEND + AW'(4 * W);
      localparam logic [AW-1:0] A_ENS  = BASE_ENS  + AW'(4 * W);
      localparam logic [AW-1:0] A_ENC  = BASE_ENC  + AW'(4 * W);
      logic idx_hit;
      assign idx_hit   = (bus_wdata == DW'(i));
      assign sw_set[i] = bus_we & (((bus_addr == OFS_SSET) & idx_hit) |
                                   ((bus_addr == A_RAW)  & bus_wdata[B]));
      assign sw_clr[i] = bus_we & (((bus_addr == OFS_SCLR) & idx_hit) |
                                   ((bus_addr == A_PEND) & bus_wdata[B]));
      assign en_set[i] = bus_we & (((bus_addr == OFS_ESET) & idx_hit) |
                                   ((bus_addr == A_ENS)  & bus_wdata[B]));
      assign en_clr[i] = bus_we & (((bus_addr == OFS_ECLR) & idx_hit) |
                                   ((bus_addr == A_ENC)  & bus_wdata[B]));
   end

   for (genvar h = 0; h < N_HOST; h++) begin : g_host
      assign hen_set[h] = bus_we & (bus_addr == OFS_HSET) & (bus_wdata == DW'(h));
      assign hen_clr[h] = bus_we & (bus_addr == OFS_HCLR) & (bus_wdata == DW'(h));
   end

   for (genvar k = 0; k < MAP_WORDS; k++) begin : g_map
      assign map_we[k] = bus_we & (bus_addr == (BASE_MAP + AW'(4 * k)));
   end

   assign gen_we = bus_we & (bus_addr == OFS_GEN);
endmodule

// File: rtl/cimap_status.sv
module cimap_status #(
   parameter int N_SRC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] sys_irq,
   input  logic [N_SRC-1:0] sw_set,
   input  logic [N_SRC-1:0] sw_clr,
   input  logic [N_SRC-1:0] en_set,
   input  logic [N_SRC-1:0] en_clr,
   output logic [N_SRC-1:0] raw_q,
   output logic [N_SRC-1:0] en_q
);
   logic [N_SRC-1:0] prev_q;
   logic [N_SRC-1:0] rise;

   assign rise = sys_irq & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         raw_q  <= '0;
         en_q   <= '0;
      end else begin
         prev_q <= sys_irq;
         // setting sources take precedence over clears
         raw_q  <= (raw_q & ~sw_clr) | sw_set | rise;
         en_q   <= (en_q & ~en_clr) | en_set;
      end
   end

   // R2
   raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(raw_q) & ~$past(sw_clr))) & ~raw_q) == '0));

   // R13
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(rise | sw_set) & ~raw_q) == '0));
endmodule

// File: rtl/cimap_chmap.sv
module cimap_chmap
   import cimap_pkg::*;
#(
   parameter int N_SRC     = 64,
   parameter int MAP_WORDS = (N_SRC + 3) / 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [MAP_WORDS-1:0]       map_we,
   input  logic [DW-1:0]              bus_wdata,
   output logic [N_SRC-1:0][7:0]      chan_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q <= '0;
      end else begin
         for (int i = 0; i < N_SRC; i++) begin
            if (map_we[i / 4]) chan_q[i] <= bus_wdata[8 * (i % 4) +: 8];
         end
      end
   end
endmodule

// File: rtl/cimap_route.sv
module cimap_route #(
   parameter int N_SRC  = 64,
   parameter int N_HOST = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_SRC-1:0]      pend,
   input  logic [N_SRC-1:0][7:0] chan,
   input  logic [N_HOST-1:0]     hen_set,
   input  logic [N_HOST-1:0]     hen_clr,
   input  logic                  gen_we,
   input  logic                  gen_wd,
   output logic                  gen_q,
   output logic [N_HOST-1:0]     host_irq
);
   logic [N_HOST-1:0] hen_q;
   logic [N_HOST-1:0] hit;

   for (genvar h = 0; h < N_HOST; h++) begin : g_host
      logic [N_SRC-1:0] sel;
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         assign sel[i] = (chan[i] == 8'(h));
      end
      assign hit[h] = |(pend & sel);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hen_q    <= '0;
         gen_q    <= 1'b0;
         host_irq <= '0;
      end else begin
         hen_q    <= (hen_q & ~hen_clr) | hen_set;
         if (gen_we) gen_q <= gen_wd;
         host_irq <= hit & hen_q & {N_HOST{gen_q}};
      end
   end

   // R6
   gen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_q |=> (host_irq == '0));

   // R5
   hen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((host_irq & ~$past(hen_q)) == '0));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> (host_irq == '0));
endmodule

// File: rtl/irq_mapper_ctrl.sv
module irq_mapper_ctrl
   import cimap_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int N_HOST = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  sys_irq,
   input  logic              bus_we,
   input  logic [12:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_HOST-1:0] host_irq
);
   localparam int N_WORDS   = (N_SRC + 31) / 32;
   localparam int MAP_WORDS = (N_SRC + 3) / 4;

   if (N_SRC < 1 || N_SRC > MAX_SRC) begin : g_bad_src
      $error("irq_mapper_ctrl: N_SRC out of range");
   end
   if (N_HOST < 1 || N_HOST > MAX_HOST) begin : g_bad_host
      $error("irq_mapper_ctrl: N_HOST out of range");
   end

   logic [N_SRC-1:0]      sw_set, sw_clr, en_set, en_clr;
   logic [N_HOST-1:0]     hen_set, hen_clr;
   logic                  gen_we, gen_q;
   logic [MAP_WORDS-1:0]  map_we;
   logic [N_SRC-1:0]      raw, en;
   logic [N_SRC-1:0][7:0] chan;

   cimap_busdec #(.N_SRC(N_SRC), .N_HOST(N_HOST), .MAP_WORDS(MAP_WORDS)) u_dec (
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .sw_set(sw_set), .sw_clr(sw_clr), .en_set(en_set), .en_clr(en_clr),
      .hen_set(hen_set), .hen_clr(hen_clr), .gen_we(gen_we), .map_we(map_we)
   );

   cimap_status #(.N_SRC(N_SRC)) u_stat (
      .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq),
      .sw_set(sw_set), .sw_clr(sw_clr), .en_set(en_set), .en_clr(en_clr),
      .raw_q(raw), .en_q(en)
   );

   cimap_chmap #(.N_SRC(N_SRC), .MAP_WORDS(MAP_WORDS)) u_map (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .bus_wdata(bus_wdata),
      .chan_q(chan)
   );

   cimap_route #(.N_SRC(N_SRC), .N_HOST(N_HOST)) u_route (
      .clk(clk), .rst_n(rst_n), .pend(raw & en), .chan(chan),
      .hen_set(hen_set), .hen_clr(hen_clr), .gen_we(gen_we),
      .gen_wd(bus_wdata[0]), .gen_q(gen_q), .host_irq(host_irq)
   );

   // read path, zero-padded to whole words
   logic [32*N_WORDS-1:0]   raw_pad, en_pad;
   logic [32*MAP_WORDS-1:0] map_pad;
   logic [4:0]              sw;
   logic [7:0]              mw;

   always_comb begin
      raw_pad = '0;
      en_pad  = '0;
      map_pad = '0;
      raw_pad[N_SRC-1:0]   = raw;
      en_pad[N_SRC-1:0]    = en;
      map_pad[8*N_SRC-1:0] = chan;
      sw        = bus_addr[6:2];
      mw        = bus_addr[9:2];
      bus_rdata = '0;
      if (bus_addr == OFS_GEN) begin
         bus_rdata = {31'd0, gen_q};
      end else if (bus_addr[12:10] == 3'b001) begin
         if (32'(mw) < MAP_WORDS) bus_rdata = map_pad[32*mw +: 32];
      end else if (32'(sw) < N_WORDS) begin
         case (bus_addr[12:7])
            BASE_RAW[12:7]:  bus_rdata = raw_pad[32*sw +: 32];
            BASE_PEND[12:7]: bus_rdata = raw_pad[32*sw +: 32] & en_pad[32*sw +: 32];
            BASE_ENS[12:7],
            BASE_ENC[12:7]:  bus_rdata = en_pad[32*sw +: 32];
            default:         bus_rdata = '0;
         endcase
      end
   end

   // R12
   oor_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == OFS_ESET || bus_addr == OFS_ECLR) &&
       (bus_wdata >= 32'(N_SRC))) |=> $stable(en));
endmodule

// File: tb/irq_mapper_ctrl_test.sv
`timescale 1ns/1ps
module irq_mapper_ctrl_test;
   localparam int NS = 40;
   localparam int NH = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] sys_irq = '0;
   logic          bus_we = 1'b0;
   logic [12:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NH-1:0] host_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_mapper_ctrl #(.N_SRC(NS), .N_HOST(NH)) uut (
      .clk(clk), .rst_n(rst_n), .sys_irq(sys_irq), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .host_irq(host_irq)
   );

   // {address, write data, expected host_irq one cycle after the write lands}
   localparam int NV = 29;
   localparam logic [50:0] VECS [0:NV-1] = '{
      {13'h010, 32'h1,        6'h00},  // R6 global on
      {13'h034, 32'd2,        6'h00},  // R5 host 2 on
      {13'h404, 32'h00000200, 6'h00},  // R7 src5 -> ch2
      {13'h020, 32'd5,        6'h00},  // R3 raw5, not enabled
      {13'h028, 32'd5,        6'h04},  // R4 enable 5
      {13'h010, 32'h0,        6'h00},  // R6 global off
      {13'h010, 32'h1,        6'h04},  // R6 host enable kept
      {13'h038, 32'd2,        6'h00},  // R5 host 2 off
      {13'h034, 32'd2,        6'h04},  // R5
      {13'h02C, 32'd5,        6'h00},  // R4 disable 5
      {13'h300, 32'h00000020, 6'h04},  // R9 bitmap enable
      {13'h024, 32'd5,        6'h00},  // R3 clear raw5
      {13'h200, 32'h00000020, 6'h04},  // R8 bitmap raw set
      {13'h280, 32'h00000020, 6'h00},  // R8 pending write clears
      {13'h020, 32'd40,       6'h00},  // R12 source index 40
      {13'h028, 32'd40,       6'h00},  // R12
      {13'h034, 32'd6,        6'h00},  // R12 host index 6
      {13'h420, 32'h00000200, 6'h00},  // R7 src33 -> ch2
      {13'h028, 32'd33,       6'h00},  // R4
      {13'h020, 32'd33,       6'h04},  // R11 second source on host 2
      {13'h020, 32'd5,        6'h04},  // R11
      {13'h024, 32'd33,       6'h04},  // R11 src5 still pending
      {13'h024, 32'd5,        6'h00},  // R11 none left
      {13'h404, 32'h07000200, 6'h00},  // R12 src7 -> ch7 (absent)
      {13'h028, 32'd7,        6'h00},  // R12
      {13'h020, 32'd7,        6'h00},  // R12 routed nowhere
      {13'h404, 32'h03000200, 6'h00},  // R7 src7 -> ch3, host 3 off
      {13'h034, 32'd3,        6'h08},  // R10
      {13'h024, 32'd7,        6'h00}   // R3
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 host_irq", 32'(host_irq), 32'h0);
      rd(13'h010, r); chk("R1 global", r, 32'h0);
      rd(13'h300, r); chk("R1 enables", r, 32'h0);
      rd(13'h200, r); chk("R1 raw", r, 32'h0);
      rd(13'h400, r); chk("R1 map", r, 32'h0);

      // table walk, R10 host output view
      for (int v = 0; v < NV; v++) begin
         wr(VECS[v][50:38], VECS[v][37:6]);
         @(negedge clk);
         if (32'(host_irq) !== 32'(VECS[v][5:0]))
            $display("vector %0d mismatch", v);
         chk("R10 vector", 32'(host_irq), 32'(VECS[v][5:0]));
      end

      // R9 and R12: enables 5,7,33 only, index 40 ignored
      rd(13'h380, r); chk("R9 enable word0", r, 32'h000000A0);
      rd(13'h304, r); chk("R12 enable word1", r, 32'h00000002);

      // R7 readback
      rd(13'h404, r); chk("R7 map word1", r, 32'h03000200);
      rd(13'h420, r); chk("R7 map word8", r, 32'h00000200);

      // R2 pulse on input 33 is held
      @(negedge clk); sys_irq[33] = 1'b1;
      @(negedge clk); sys_irq[33] = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R2 host after pulse", 32'(host_irq), 32'h04);
      rd(13'h204, r); chk("R8 raw word1", r, 32'h2);
      rd(13'h284, r); chk("R8 pending word1", r, 32'h2);

      // R2 held level does not re-set after clear
      @(negedge clk); sys_irq[33] = 1'b1;
      wr(13'h024, 32'd33);
      rd(13'h204, r); chk("R2 cleared under level", r, 32'h0);
      @(negedge clk); @(negedge clk);
      rd(13'h204, r); chk("R2 stays clear", r, 32'h0);
      chk("R2 host low", 32'(host_irq), 32'h0);
      sys_irq[33] = 1'b0;

      // R13 edge and clear in one cycle
      @(negedge clk);
      sys_irq[32] = 1'b1;
      bus_addr    = 13'h024;
      bus_wdata   = 32'd32;
      bus_we      = 1'b1;
      @(negedge clk);
      bus_we      = 1'b0;
      sys_irq[32] = 1'b0;
      rd(13'h204, r); chk("R13 set wins", r, 32'h1);
      wr(13'h284, 32'h1);
      rd(13'h204, r); chk("R8 pending write clears unenabled", r, 32'h0);

      // R10 one-cycle latency
      wr(13'h020, 32'd5);
      chk("R10 not yet", 32'(host_irq), 32'h0);
      @(negedge clk);
      chk("R10 asserted", 32'(host_irq), 32'h04);
      wr(13'h024, 32'd5);

      // R6 readback
      rd(13'h010, r); chk("R6 global readback", r, 32'h1);

      finish_run();
   end
endmodule